// File: doc/BRIEF.md
# Four-Lane Idle-Column Elastic Buffer

This block sits in a four-lane receive path after 8b/10b decoding, lane alignment and deskew. Each lane presents one byte and one control flag per recovered-clock cycle. The four lanes together form a column. Columns are written on the recovered clock and read on the local reference clock. The two clocks may differ by up to 100 ppm each way, so 200 ppm in total. The buffer absorbs that difference by keeping its fill level near the middle. It never drops or repeats a column that carries data. It only removes or duplicates idle columns, that is, cycles in which every lane carries the idle control character K28.0.

The write side runs a small state machine with the states WR_OFF, WR_RUN and WR_FAULT. The transitions are:
- WR_OFF to WR_RUN, taken once lane sync and deskew alignment are both high.
- WR_RUN to WR_FAULT, taken when a column has to be written into a full buffer.

The read side runs the states RD_OFF, RD_RUN and RD_FAULT. The transitions are:
- RD_OFF to RD_RUN, taken when the read-side fill level reaches half the depth.
- RD_RUN to RD_FAULT, taken when the buffer is empty while running.

Both fault states hold until the receiver reset is applied. Deletions happen on the write side and insertions on the read side. Every event is reported in the read clock domain by a one-cycle pulse on all four lane flags.

Top module: `rmf_column_fifo`

## Requirements
- R1: While `pcs_rst` is high, every output is zero.
- R2: No column is stored, and `rd_valid` stays low, unless `lane_sync` and `lane_aligned` have both been high together since reset.
- R3: Every non-idle column leaves on `rd_data`/`rd_ctl` unmodified, in arrival order, exactly once. A lane is idle when its control bit is 1 and its byte is 8'h1C. Lane i uses bits [8i+7:8i] of the data and bit i of the control.
- R4: A column in which only some lanes are idle counts as data. It is never removed or repeated.
- R5: On the write side, an all-idle column is discarded when the write-side fill level exceeds DEPTH/2+2 and the previous column was not itself discarded.
- R6: On the read side, when the head column is all-idle and the read-side fill level is below DEPTH/2-2, that column is output without being consumed. It is then output again later.
- R7: For each discarded column, `del_flag` is 4'b1111 for one read cycle. That cycle is the one that outputs the next stored column. `del_flag` and `ins_flag` are never high together.
- R8: For each duplicated column, `ins_flag` is 4'b1111 for one read cycle, alongside that idle column with `rd_valid` high. Otherwise the flags are 4'b0000.
- R9: After enabling, output begins only once at least DEPTH/2 columns have been written.
- R10: A write into a full buffer raises `wr_full` and stops writing. `wr_full` stays high until reset, and the fill level never exceeds DEPTH.
- R11: An empty buffer while reading raises `rd_empty` and stops the output. `rd_empty` stays high, with `rd_valid` low, until reset.
- R12: Reset empties the buffer, clears both fault flags and returns both sides to the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| rd_clk | input | 1 | Local reference (read) clock |
| pcs_rst | input | 1 | Receiver reset, asynchronous, active high |
| col_data_i | input | LANES*8 | Incoming column bytes, lane i in bits [8i+7:8i] |
| col_ctl_i | input | LANES | Incoming control flags, one per lane |
| lane_sync | input | 1 | Word alignment reports all lanes in sync |
| lane_aligned | input | 1 | Deskew reports lanes aligned |
| wr_full | output | 1 | Overflow fault, held until reset |
| rd_data | output | LANES*8 | Outgoing column bytes |
| rd_ctl | output | LANES | Outgoing control flags |
| rd_valid | output | 1 | A column is present on the read outputs |
| rd_empty | output | 1 | Underflow fault, held until reset |
| ins_flag | output | LANES | Per-lane idle-column insertion pulse |
| del_flag | output | LANES | Per-lane idle-column deletion pulse |

## Verification
The bench builds the block with its defaults: four lanes and a depth of 16. That puts the delete threshold at 10, the insert threshold at 6 and the read start at 8. The two clock periods are skewed by 5 percent in each direction. This exaggerates the drift, so both thresholds are crossed within a few dozen columns. With 16 entries, a stream with no idle columns reaches the full and empty faults within a few hundred cycles. The same depth still leaves room above the pointer-synchronizer lag, so ordinary matching never faults by accident.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
    // control byte that marks an idle lane (K28.0)
    localparam logic [7:0] K_IDLE = 8'h1C;

    typedef enum logic [1:0] {
        WR_OFF   = 2'd0,
        WR_RUN   = 2'd1,
        WR_FAULT = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_OFF   = 2'd0,
        RD_RUN   = 2'd1,
        RD_FAULT = 2'd2
    } rd_state_e;
endpackage

// File: rtl/rmf_idle_detect.sv
module rmf_idle_detect #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] col_data,
    input  logic [LANES-1:0]   col_ctl,
    output logic               all_idle
);
    logic [LANES-1:0] lane_idle;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_idle[i] = col_ctl[i] && (col_data[8*i +: 8] == rmf_pkg::K_IDLE);
    end

    assign all_idle = &lane_idle;
endmodule

// File: rtl/rmf_gray_sync.sv
module rmf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage1   <= '0;
            gray_out <= '0;
        end else begin
            stage1   <= gray_in;
            gray_out <= stage1;
        end
    end
endmodule

// File: rtl/rmf_col_mem.sv
module rmf_col_mem #(
    parameter int W     = 37,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rmf_write_ctrl.sv
module rmf_write_ctrl
    import rmf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic               wr_clk,
    input  logic               rst,
    input  logic [LANES*8-1:0] col_data,
    input  logic [LANES-1:0]   col_ctl,
    input  logic               lane_sync,
    input  logic               lane_aligned,
    input  logic [PW-1:0]      rptr_gray_s,
    output logic               mem_we,
    output logic [AW-1:0]      mem_waddr,
    output logic               mem_mark,
    output logic [PW-1:0]      wptr_gray,
    output logic [PW-1:0]      occ,
    output logic               wr_full
);
    localparam logic [PW-1:0] HI_LIM   = PW'(DEPTH / 2 + 2);
    localparam logic [PW-1:0] FULL_LIM = PW'(DEPTH);

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int k = PW - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

    wr_state_e     state_q, state_d;
    logic [PW-1:0] wptr_q, wptr_d;
    logic          del_pend_q;
    logic          col_idle;
    logic          do_del, do_wr;

    rmf_idle_detect #(.LANES(LANES)) u_idle (
        .col_data (col_data),
        .col_ctl  (col_ctl),
        .all_idle (col_idle)
    );

    assign occ    = wptr_q - gray2bin(rptr_gray_s);
    assign wptr_d = wptr_q + PW'(do_wr);

    // next state and write decision
    always_comb begin
        state_d = state_q;
        do_del  = 1'b0;
        do_wr   = 1'b0;
        unique case (state_q)
            WR_OFF: begin
                if (lane_sync && lane_aligned) begin
                    state_d = WR_RUN;
                end
            end
            WR_RUN: begin
                if (col_idle && (occ > HI_LIM) && !del_pend_q) begin
                    do_del = 1'b1;
                end else if (occ >= FULL_LIM) begin
                    state_d = WR_FAULT;
                end else begin
                    do_wr = 1'b1;
                end
            end
            WR_FAULT: state_d = WR_FAULT;
            default:  state_d = WR_OFF;
        endcase
    end

    // state register
    always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) begin
            state_q <= WR_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // pointer and deletion marker
    always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) begin
            wptr_q     <= '0;
            wptr_gray  <= '0;
            del_pend_q <= 1'b0;
        end else begin
            wptr_q    <= wptr_d;
            wptr_gray <= wptr_d ^ (wptr_d >> 1);
            if (do_del) begin
                del_pend_q <= 1'b1;
            end else if (do_wr) begin
                del_pend_q <= 1'b0;
            end
        end
    end

    assign mem_we    = do_wr;
    assign mem_waddr = wptr_q[AW-1:0];
    assign mem_mark  = del_pend_q;
    assign wr_full   = (state_q == WR_FAULT);
endmodule

// File: rtl/rmf_read_ctrl.sv
module rmf_read_ctrl
    import rmf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic               rd_clk,
    input  logic               rst,
    input  logic [PW-1:0]      wptr_gray_s,
    input  logic [LANES*8-1:0] head_data,
    input  logic [LANES-1:0]   head_ctl,
    input  logic               head_mark,
    output logic [AW-1:0]      raddr,
    output logic [PW-1:0]      rptr_gray,
    output logic [LANES*8-1:0] rd_data,
    output logic [LANES-1:0]   rd_ctl,
    output logic               rd_valid,
    output logic               rd_empty,
    output logic [LANES-1:0]   ins_flag,
    output logic [LANES-1:0]   del_flag
);
    localparam logic [PW-1:0] MID_LIM = PW'(DEPTH / 2);
    localparam logic [PW-1:0] LO_LIM  = PW'(DEPTH / 2 - 2);

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int k = PW - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

    rd_state_e     state_q, state_d;
    logic [PW-1:0] rptr_q, rptr_d;
    logic [PW-1:0] occ;
    logic          head_idle;
    logic          do_pop, do_ins;

    rmf_idle_detect #(.LANES(LANES)) u_idle (
        .col_data (head_data),
        .col_ctl  (head_ctl),
        .all_idle (head_idle)
    );

    assign occ    = gray2bin(wptr_gray_s) - rptr_q;
    assign rptr_d = rptr_q + PW'(do_pop);

    // next state and read decision
    always_comb begin
        state_d = state_q;
        do_pop  = 1'b0;
        do_ins  = 1'b0;
        unique case (state_q)
            RD_OFF: begin
                if (occ >= MID_LIM) begin
                    state_d = RD_RUN;
                end
            end
            RD_RUN: begin
                if (occ == '0) begin
                    state_d = RD_FAULT;
                end else if (head_idle && (occ < LO_LIM)) begin
                    do_ins = 1'b1;
                end else begin
                    do_pop = 1'b1;
                end
            end
            RD_FAULT: state_d = RD_FAULT;
            default:  state_d = RD_OFF;
        endcase
    end

    // state register
    always_ff @(posedge rd_clk or posedge rst) begin
        if (rst) begin
            state_q <= RD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and pointer
    always_ff @(posedge rd_clk or posedge rst) begin
        if (rst) begin
            rptr_q    <= '0;
            rptr_gray <= '0;
            rd_data   <= '0;
            rd_ctl    <= '0;
            rd_valid  <= 1'b0;
            rd_empty  <= 1'b0;
            ins_flag  <= '0;
            del_flag  <= '0;
        end else begin
            rptr_q    <= rptr_d;
            rptr_gray <= rptr_d ^ (rptr_d >> 1);
            rd_valid  <= do_pop | do_ins;
            rd_data   <= (do_pop | do_ins) ? head_data : '0;
            rd_ctl    <= (do_pop | do_ins) ? head_ctl : '0;
            ins_flag  <= {LANES{do_ins}};
            del_flag  <= {LANES{do_pop && head_mark}};
            rd_empty  <= (state_d == RD_FAULT);
        end
    end

    assign raddr = rptr_q[AW-1:0];
endmodule

// File: rtl/rmf_column_fifo.sv
module rmf_column_fifo #(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic               wr_clk,
    input  logic               rd_clk,
    input  logic               pcs_rst,
    input  logic [LANES*8-1:0] col_data_i,
    input  logic [LANES-1:0]   col_ctl_i,
    input  logic               lane_sync,
    input  logic               lane_aligned,
    output logic               wr_full,
    output logic [LANES*8-1:0] rd_data,
    output logic [LANES-1:0]   rd_ctl,
    output logic               rd_valid,
    output logic               rd_empty,
    output logic [LANES-1:0]   ins_flag,
    output logic [LANES-1:0]   del_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int CW = LANES * 9 + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic          mem_mark;
    logic [CW-1:0] mem_wdata, mem_rdata;
    logic [PW-1:0] wptr_gray, wptr_gray_s;
    logic [PW-1:0] rptr_gray, rptr_gray_s;
    logic [PW-1:0] wr_occ;

    assign mem_wdata = {mem_mark, col_ctl_i, col_data_i};

    rmf_write_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_wr (
        .wr_clk       (wr_clk),
        .rst          (pcs_rst),
        .col_data     (col_data_i),
        .col_ctl      (col_ctl_i),
        .lane_sync    (lane_sync),
        .lane_aligned (lane_aligned),
        .rptr_gray_s  (rptr_gray_s),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_mark     (mem_mark),
        .wptr_gray    (wptr_gray),
        .occ          (wr_occ),
        .wr_full      (wr_full)
    );

    rmf_col_mem #(.W(CW), .DEPTH(DEPTH)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    rmf_gray_sync #(.W(PW)) u_wsync (
        .clk      (rd_clk),
        .rst      (pcs_rst),
        .gray_in  (wptr_gray),
        .gray_out (wptr_gray_s)
    );

    rmf_gray_sync #(.W(PW)) u_rsync (
        .clk      (wr_clk),
        .rst      (pcs_rst),
        .gray_in  (rptr_gray),
        .gray_out (rptr_gray_s)
    );

    rmf_read_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_rd (
        .rd_clk      (rd_clk),
        .rst         (pcs_rst),
        .wptr_gray_s (wptr_gray_s),
        .head_data   (mem_rdata[LANES*8-1:0]),
        .head_ctl    (mem_rdata[LANES*9-1:LANES*8]),
        .head_mark   (mem_rdata[CW-1]),
        .raddr       (mem_raddr),
        .rptr_gray   (rptr_gray),
        .rd_data     (rd_data),
        .rd_ctl      (rd_ctl),
        .rd_valid    (rd_valid),
        .rd_empty    (rd_empty),
        .ins_flag    (ins_flag),
        .del_flag    (del_flag)
    );
endmodule

// File: rtl/rmf_checks.sv
module rmf_checks #(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic               wr_clk,
    input logic               rd_clk,
    input logic               pcs_rst,
    input logic               lane_sync,
    input logic               lane_aligned,
    input logic               mem_we,
    input logic [PW-1:0]      wr_occ,
    input logic               wr_full,
    input logic [LANES*8-1:0] rd_data,
    input logic [LANES-1:0]   rd_ctl,
    input logic               rd_valid,
    input logic               rd_empty,
    input logic [LANES-1:0]   ins_flag,
    input logic [LANES-1:0]   del_flag
);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    logic [LANES-1:0] out_lane_idle;
    logic             out_idle;
    logic             en_seen;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign out_lane_idle[i] = rd_ctl[i] && (rd_data[8*i +: 8] == rmf_pkg::K_IDLE);
    end
    assign out_idle = &out_lane_idle;

    always_ff @(posedge wr_clk or posedge pcs_rst) begin
        if (pcs_rst) begin
            en_seen <= 1'b0;
        end else if (lane_sync && lane_aligned) begin
            en_seen <= 1'b1;
        end
    end

    p_no_write_disabled_r2: assert property (@(posedge wr_clk) disable iff (pcs_rst)
        mem_we |-> en_seen);

    p_ins_is_idle_r6: assert property (@(posedge rd_clk) disable iff (pcs_rst)
        ins_flag[0] |-> (rd_valid && out_idle));

    p_del_all_lanes_r7: assert property (@(posedge rd_clk) disable iff (pcs_rst)
        (del_flag == '0) || (del_flag == '1));

    p_flags_exclusive_r7: assert property (@(posedge rd_clk) disable iff (pcs_rst)
        !(ins_flag[0] && del_flag[0]));

    p_ins_all_lanes_r8: assert property (@(posedge rd_clk) disable iff (pcs_rst)
        (ins_flag == '0) || (ins_flag == '1));

    p_no_overflow_r10: assert property (@(posedge wr_clk) disable iff (pcs_rst)
        wr_occ <= FULL_V);

    p_full_hold_r10: assert property (@(posedge wr_clk) disable iff (pcs_rst)
        wr_full |=> wr_full);

    p_empty_hold_r11: assert property (@(posedge rd_clk) disable iff (pcs_rst)
        rd_empty |=> (rd_empty && !rd_valid));
endmodule

bind rmf_column_fifo rmf_checks #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .pcs_rst      (pcs_rst),
    .lane_sync    (lane_sync),
    .lane_aligned (lane_aligned),
    .mem_we       (mem_we),
    .wr_occ       (wr_occ),
    .wr_full      (wr_full),
    .rd_data      (rd_data),
    .rd_ctl       (rd_ctl),
    .rd_valid     (rd_valid),
    .rd_empty     (rd_empty),
    .ins_flag     (ins_flag),
    .del_flag     (del_flag)
);

// File: tb/rmf_column_fifo_bench.sv
`timescale 1ns/1ps
module rmf_column_fifo_bench;
    localparam int LANES = 4;
    localparam int DEPTH = 16;
    localparam logic [31:0] IDLE_D = 32'h1C1C1C1C;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        pcs_rst = 1'b1;
    logic [31:0] col_data_i = '0;
    logic [3:0]  col_ctl_i = '0;
    logic        lane_sync = 1'b0, lane_aligned = 1'b0;
    logic        wr_full, rd_valid, rd_empty;
    logic [31:0] rd_data;
    logic [3:0]  rd_ctl, ins_flag, del_flag;

    realtime wr_half = 10.0, rd_half = 10.0;
    int  errors = 0, checks = 0;
    int  ins_cnt = 0, del_cnt = 0, part_cnt = 0;
    int  sent_since_en = 0, first_valid_at = -1;
    bit  track = 0, sb_on = 0, measure = 0, seen_valid = 0;
    logic [7:0]  seq = 8'h20;
    logic [35:0] expq[$];

    rmf_column_fifo #(.LANES(LANES), .DEPTH(DEPTH)) u_rmf_column_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .pcs_rst(pcs_rst),
        .col_data_i(col_data_i), .col_ctl_i(col_ctl_i),
        .lane_sync(lane_sync), .lane_aligned(lane_aligned),
        .wr_full(wr_full), .rd_data(rd_data), .rd_ctl(rd_ctl),
        .rd_valid(rd_valid), .rd_empty(rd_empty),
        .ins_flag(ins_flag), .del_flag(del_flag)
    );

    initial forever #(wr_half) wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // driver: one column per write cycle, data columns go to the scoreboard
    task automatic send_col(input logic [31:0] d, input logic [3:0] c);
        @(negedge wr_clk);
        col_data_i = d;
        col_ctl_i  = c;
        sent_since_en++;
        if (track && !(c == 4'hF && d == IDLE_D)) expq.push_back({c, d});
    endtask

    task automatic send_data();
        send_col({seq + 8'd3, seq + 8'd2, seq + 8'd1, seq}, 4'h0);
        seq = seq + 8'd4;
    endtask

    task automatic send_pattern(input int rounds);
        for (int r = 0; r < rounds; r++) begin
            send_data();
            send_data();
            send_col({seq, 8'h1C, 8'h1C, 8'h1C}, 4'b0111); // R4 partial idle
            seq = seq + 8'd1;
            send_col(IDLE_D, 4'hF);
            send_col(IDLE_D, 4'hF);
        end
    endtask

    task automatic do_reset();
        pcs_rst = 1'b1;
        lane_sync = 1'b0;
        lane_aligned = 1'b0;
        track = 0;
        sb_on = 0;
        expq.delete();
        repeat (4) @(negedge rd_clk);
        chk(rd_valid == 0 && wr_full == 0 && rd_empty == 0 && ins_flag == 0 && del_flag == 0,
            "R12 outputs cleared by reset", {wr_full, rd_empty, rd_valid}, 0);
        @(negedge wr_clk);
        pcs_rst = 1'b0;
        seen_valid = 0;
        for (int k = 0; k < 30; k++) send_col(IDLE_D, 4'hF);
        chk(seen_valid == 0, "R12 disabled after reset", seen_valid, 0);
        ins_cnt = 0;
        del_cnt = 0;
        part_cnt = 0;
    endtask

    task automatic enable_and_prime();
        sent_since_en = 0;
        first_valid_at = -1;
        measure = 1;
        lane_sync = 1'b1;
        lane_aligned = 1'b1;
        for (int k = 0; k < 8; k++) send_col(IDLE_D, 4'hF);
        sb_on = 1;
        track = 1;
    endtask

    // monitor: scoreboard compare and flag checks, sampled away from the edge
    always @(negedge rd_clk) begin
        if (!pcs_rst) begin
            if (rd_valid) begin
                seen_valid = 1;
                if (measure && first_valid_at < 0) first_valid_at = sent_since_en;
                if (sb_on && !(rd_ctl == 4'hF && rd_data == IDLE_D)) begin
                    if (expq.size() == 0) begin
                        chk(0, "R3 unexpected column", {rd_ctl, rd_data}, 0);
                    end else begin
                        logic [35:0] e;
                        e = expq.pop_front();
                        chk({rd_ctl, rd_data} == e, "R3 column order and content", {rd_ctl, rd_data}, e);
                        if (rd_ctl == 4'b0111) part_cnt++;
                    end
                end
            end
            if (ins_flag != 0) begin
                ins_cnt++;
                chk(ins_flag == 4'hF && rd_valid && rd_ctl == 4'hF && rd_data == IDLE_D,
                    "R8 insert pulse on idle column", {ins_flag, rd_ctl, rd_data}, {4'hF, 4'hF, IDLE_D});
            end
            if (del_flag != 0) begin
                del_cnt++;
                chk(del_flag == 4'hF && rd_valid && ins_flag == 0,
                    "R7 delete pulse all lanes", {del_flag, ins_flag}, {4'hF, 4'h0});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge rd_clk);
        chk(rd_valid == 0 && rd_data == 0 && rd_ctl == 0 && wr_full == 0 && rd_empty == 0
            && ins_flag == 0 && del_flag == 0, "R1 reset outputs", {rd_valid, wr_full, rd_empty}, 0);
        @(negedge wr_clk);
        pcs_rst = 1'b0;

        // R2: only one of the two enables at a time
        lane_sync = 1'b1;
        for (int k = 0; k < 30; k++) send_data();
        lane_sync = 1'b0;
        lane_aligned = 1'b1;
        for (int k = 0; k < 30; k++) send_data();
        for (int k = 0; k < 10; k++) send_col(IDLE_D, 4'hF);
        chk(seen_valid == 0, "R2 no output before both enables", seen_valid, 0);

        // write clock faster: deletions expected
        wr_half = 9.5;
        enable_and_prime();
        send_pattern(120);
        track = 0;
        for (int k = 0; k < 80; k++) send_col(IDLE_D, 4'hF);
        chk(first_valid_at >= DEPTH / 2, "R9 output starts at half fill", first_valid_at, DEPTH / 2);
        chk(expq.size() == 0, "R3 all data delivered (fast write)", expq.size(), 0);
        chk(part_cnt == 120, "R4 partial idle columns kept", part_cnt, 120);
        chk(del_cnt > 0, "R5 deletions occurred", del_cnt, 1);
        chk(wr_full == 0 && rd_empty == 0, "R10 no fault while matching", {wr_full, rd_empty}, 0);
        measure = 0;

        do_reset();
        // write clock slower: insertions expected
        wr_half = 10.5;
        enable_and_prime();
        send_pattern(120);
        track = 0;
        for (int k = 0; k < 80; k++) send_col(IDLE_D, 4'hF);
        chk(expq.size() == 0, "R3 all data delivered (slow write)", expq.size(), 0);
        chk(part_cnt == 120, "R4 partial idle columns kept (slow)", part_cnt, 120);
        chk(ins_cnt > 0, "R6 insertions occurred", ins_cnt, 1);
        chk(wr_full == 0 && rd_empty == 0, "R11 no fault while matching", {wr_full, rd_empty}, 0);
        measure = 0;

        // overflow: no idle columns, write faster
        do_reset();
        wr_half = 9.5;
        lane_sync = 1'b1;
        lane_aligned = 1'b1;
        for (int k = 0; k < 1000 && !wr_full; k++) send_data();
        chk(wr_full == 1, "R10 full flag raised", wr_full, 1);
        for (int k = 0; k < 20; k++) send_data();
        chk(wr_full == 1, "R10 full flag held", wr_full, 1);

        // underflow: no idle columns, write slower
        do_reset();
        chk(wr_full == 0, "R12 full cleared by reset", wr_full, 0);
        wr_half = 10.5;
        lane_sync = 1'b1;
        lane_aligned = 1'b1;
        for (int k = 0; k < 1000 && !rd_empty; k++) send_data();
        chk(rd_empty == 1, "R11 empty flag raised", rd_empty, 1);
        repeat (10) @(negedge rd_clk);
        chk(rd_empty == 1 && rd_valid == 0, "R11 empty held, output stopped", {rd_empty, rd_valid}, 2'b10);

        do_reset();
        chk(rd_empty == 0, "R12 empty cleared by reset", rd_empty, 0);

        summary();
        $finish;
    end
endmodule